// File: doc/BRIEF.md
# Switch Output Pin Mapper

This block drives eight switch-control pins from two four-bit switch state groups: a committed group (low/high band, polarisation, satellite position, option position) and an uncommitted group (four general switches). A packed configuration byte chooses how the groups reach the pins. The choices are a direct pass-through, a mirrored mode where the upper pins repeat the committed group inverted, and a one-of-eight decoder that turns three adjacent lines of one group into a single active pin. The decoder also has a narrower one-of-four form that uses two lines.

State bits and the configuration byte arrive on plain input ports. Pins are registered, so every change appears on the clock edge after the input change. Configuration byte layout: bit 0 and bit 7 are not used here. Bits 4:1 hold a decoder selector, where 0 means off and 1 to 8 choose a decoder setting. Bit 5 enables mirrored mode. Bit 6 enables the two-line decoder form. Pin bit i drives pin OP(i+1).

Top module: `swout_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight pins are low after that edge.
- R2: Pins are registered. A change on `com_state`, `unc_state` or `cfg` shows on `op` only after the next rising clock edge, and `op` holds between edges.
- R3: With the selector (cfg[4:1]) at 0 and cfg[5] low, pass-through applies. op[0]=Hi/Lo (com_state[0]), op[1]=polarisation (com_state[1]), op[2]=position (com_state[2]), op[3]=option (com_state[3]), and op[7:4]=unc_state[3:0].
- R4: With the selector at 0 and cfg[5] high, op[3:0]=com_state and op[7:4]=~com_state.
- R5: For a selector value n from 1 to 8, let m=n-1. The source group is com_state when m[2]=0 and unc_state when m[2]=1. The three lines taken from it are bits m[0]..m[0]+2 of that group, with the lowest line as the index LSB. When m[1]=0, exactly the pin op[index] is high.
- R6: For selector values 3, 4, 7 and 8 (m[1]=1), the decoded pattern is inverted: op[index] is low and the other seven pins are high.
- R7: With cfg[6] high in decoded mode, the lowest of the three lines is taken as 0. Only op[0], op[2], op[4] and op[6] can be the selected pin (one of four).
- R8: A selector value from 1 to 8 takes priority over cfg[5]. The decoder result is driven even when cfg[5] is high.
- R9: Selector values 9 to 15 act as a selector of 0, falling back to R3 or R4 according to cfg[5].
- R10: cfg[0] and cfg[7] never affect `op`. cfg[6] has no effect unless the decoder is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| com_state | input | 4 | Committed switch state (Hi/Lo, polarisation, position, option) |
| unc_state | input | 4 | Uncommitted switch state, switches 5 to 8 |
| cfg | input | 8 | Output configuration byte |
| op | output | 8 | Registered pin levels, bit i drives OP(i+1) |

## Verification
A configuration change and a state change can reach the register in the same cycle. So can the decoder selector and the mirror bit, which request conflicting mappings. The bench drives each combination on one falling edge. Before the next rising edge it confirms that the old pin value is still held. After that edge it compares the pins against the mapping that the new configuration gives for the new state. This shows that the pins never carry a blend of the old and new mapping and that the decoder wins over mirroring.

// File: rtl/swout_pkg.sv
package swout_pkg;

    typedef enum logic [1:0] {
        MAP_PASS   = 2'd0,
        MAP_MIRROR = 2'd1,
        MAP_DECODE = 2'd2
    } map_mode_e;

    typedef struct packed {
        map_mode_e mode;
        logic      use_unc;
        logic      start;
        logic      active_low;
        logic      two_line;
    } map_sel_t;

endpackage

// File: rtl/swout_cfg_decode.sv
module swout_cfg_decode
    import swout_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int SEL_LSB   = 1,
    parameter int SEL_W     = 4,
    parameter int MIR_BIT   = 5,
    parameter int TWO_BIT   = 6,
    parameter int DEC_MODES = 8
) (
    input  logic [CFG_W-1:0] cfg,
    output map_sel_t         sel
);
    localparam int M_W = $clog2(DEC_MODES);

    logic [SEL_W-1:0] num;
    logic [SEL_W-1:0] m_full;
    logic [M_W-1:0]   m;
    logic             dec_on;
    logic             unused_cfg_bits;

    assign num    = cfg[SEL_LSB +: SEL_W];
    assign m_full = num - SEL_W'(1);
    assign m      = m_full[M_W-1:0];
    assign dec_on = (num != '0) && (num <= SEL_W'(DEC_MODES));
    assign unused_cfg_bits = ^{cfg[0], cfg[CFG_W-1], m_full};

    always_comb begin
        sel            = '0;
        sel.two_line   = cfg[TWO_BIT];
        sel.start      = m[0];
        sel.active_low = m[1];
        sel.use_unc    = m[M_W-1];
        if (dec_on)            sel.mode = MAP_DECODE;
        else if (cfg[MIR_BIT]) sel.mode = MAP_MIRROR;
        else                   sel.mode = MAP_PASS;
    end

endmodule

// File: rtl/swout_line_pick.sv
module swout_line_pick #(
    parameter int GROUP_W = 4,
    parameter int LINES_W = 3
) (
    input  logic [GROUP_W-1:0] com_grp,
    input  logic [GROUP_W-1:0] unc_grp,
    input  logic               use_unc,
    input  logic               start,
    output logic [LINES_W-1:0] lines
);
    localparam int WINDOWS = GROUP_W - LINES_W + 1;

    logic [GROUP_W-1:0] grp;
    logic [LINES_W-1:0] win [WINDOWS];

    assign grp = use_unc ? unc_grp : com_grp;

    for (genvar g = 0; g < WINDOWS; g++) begin : g_win
        assign win[g] = grp[g +: LINES_W];
    end

    assign lines = win[start];

endmodule

// File: rtl/swout_onehot.sv
module swout_onehot #(
    parameter int LINES_W = 3,
    parameter int NUM_OUT = 8
) (
    input  logic [LINES_W-1:0] lines,
    input  logic               two_line,
    input  logic               active_low,
    output logic [NUM_OUT-1:0] pattern
);
    logic [LINES_W-1:0] idx;
    logic [NUM_OUT-1:0] hot;

    assign idx = two_line ? {lines[LINES_W-1:1], 1'b0} : lines;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_hot
        assign hot[i] = (idx == LINES_W'(i));
    end

    assign pattern = hot ^ {NUM_OUT{active_low}};

    always_comb begin
        if (two_line)
            assert_two_line_even_R7: assert ((hot & {(NUM_OUT/2){2'b10}}) == '0);
    end

endmodule

// File: rtl/swout_mapper.sv
module swout_mapper
    import swout_pkg::*;
#(
    parameter int GROUP_W = 4,
    parameter int CFG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] com_state,
    input  logic [GROUP_W-1:0] unc_state,
    input  logic [CFG_W-1:0]   cfg,
    output logic [2*GROUP_W-1:0] op
);
    localparam int NUM_OUT = 2 * GROUP_W;
    localparam int LINES_W = $clog2(NUM_OUT);

    typedef struct packed {
        logic [NUM_OUT-1:0] pins;
    } regs_t;

    regs_t    st_d, st_q;
    map_sel_t sel;
    logic [LINES_W-1:0] lines;
    logic [NUM_OUT-1:0] dec_pat;

    swout_cfg_decode #(
        .CFG_W     (CFG_W),
        .DEC_MODES (NUM_OUT)
    ) u_cfg (
        .cfg (cfg),
        .sel (sel)
    );

    swout_line_pick #(
        .GROUP_W (GROUP_W),
        .LINES_W (LINES_W)
    ) u_pick (
        .com_grp (com_state),
        .unc_grp (unc_state),
        .use_unc (sel.use_unc),
        .start   (sel.start),
        .lines   (lines)
    );

    swout_onehot #(
        .LINES_W (LINES_W),
        .NUM_OUT (NUM_OUT)
    ) u_hot (
        .lines      (lines),
        .two_line   (sel.two_line),
        .active_low (sel.active_low),
        .pattern    (dec_pat)
    );

    always_comb begin
        st_d = st_q;
        unique case (sel.mode)
            MAP_DECODE: st_d.pins = dec_pat;
            MAP_MIRROR: st_d.pins = {~com_state, com_state};
            default:    st_d.pins = {unc_state, com_state};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op = st_q.pins;

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> op == '0);

    assert_pass_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mode == MAP_PASS) |=> op == $past({unc_state, com_state}));

    assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mode == MAP_MIRROR) |=> op[NUM_OUT-1:GROUP_W] == ~op[GROUP_W-1:0]);

    assert_single_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mode == MAP_DECODE && !sel.active_low) |=> $countones(op) == 1);

    assert_single_cold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mode == MAP_DECODE && sel.active_low) |=> $countones(~op) == 1);

    assert_decode_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mode == MAP_DECODE && cfg[5]) |=> op == $past(dec_pat));

endmodule

// File: tb/swout_mapper_test.sv
module swout_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] com_state = '0;
    logic [3:0] unc_state = '0;
    logic [7:0] cfg = '0;
    logic [7:0] op;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    swout_mapper uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .com_state (com_state),
        .unc_state (unc_state),
        .cfg       (cfg),
        .op        (op)
    );

    function automatic logic [7:0] model(logic [3:0] c, logic [3:0] u, logic [7:0] g);
        logic [3:0] n;
        logic [2:0] m;
        logic [3:0] grp;
        logic [3:0] sh;
        logic [2:0] idx;
        logic [7:0] v;
        n = g[4:1];
        if (n >= 4'd1 && n <= 4'd8) begin
            m   = 3'(n - 4'd1);
            grp = m[2] ? u : c;
            sh  = grp >> m[0];
            idx = g[6] ? {sh[2], sh[1], 1'b0} : sh[2:0];
            v   = 8'd1 << idx;
            return m[1] ? ~v : v;
        end
        if (g[5]) return {~c, c};
        return {u, c};
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic apply(logic [3:0] c, logic [3:0] u, logic [7:0] g);
        @(negedge clk);
        com_state = c;
        unc_state = u;
        cfg = g;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        com_state = 4'hF; unc_state = 4'hF; cfg = 8'h00;
        repeat (2) @(negedge clk);
        check("R1 reset low", op, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 release", op, 8'hFF);
    endtask

    task automatic t_pass();
        apply(4'b0001, 4'b0000, 8'h00); check("R3 hilo->OP1", op, 8'h01);
        apply(4'b1010, 4'b0101, 8'h00); check("R3 mix", op, 8'h5A);
        apply(4'b0100, 4'b1000, 8'h81); check("R10 b0 b7 pass", op, 8'h84);
        apply(4'b0011, 4'b1100, 8'h40); check("R10 two-line ignored pass", op, 8'hC3);
    endtask

    task automatic t_hold();
        apply(4'h0, 4'h0, 8'h00);
        @(negedge clk);
        com_state = 4'h9; unc_state = 4'h6;
        #2;
        check("R2 held before edge", op, 8'h00);
        @(negedge clk);
        check("R2 updated after edge", op, 8'h69);
        @(negedge clk);
        check("R2 stable", op, 8'h69);
    endtask

    task automatic t_mirror();
        apply(4'b0110, 4'b1111, 8'h20); check("R4 mirror", op, 8'h96);
        apply(4'b0000, 4'b0000, 8'hE1); check("R10 mirror b6 b7 b0", op, 8'hF0);
    endtask

    task automatic t_decode();
        apply(4'b0101, 4'h0, 8'h02); check("R5 n1", op, 8'h20);
        apply(4'b0110, 4'h0, 8'h04); check("R5 n2", op, 8'h08);
        apply(4'h0, 4'b1000, 8'h0C); check("R5 n6 unc", op, 8'h10);
        apply(4'h0, 4'hF, 8'h06);    check("R6 n3 low", op, 8'hFE);
        apply(4'h0, 4'b1110, 8'h10); check("R6 n8 low", op, 8'h7F);
        apply(4'b0101, 4'h0, 8'h82); check("R10 b7 decode", op, 8'h20);
        for (int n = 1; n <= 8; n++) begin
            for (int s = 0; s < 16; s++) begin
                apply(4'(s), 4'(15 - s), 8'(n << 1));
                check((n == 3 || n == 4 || n == 7 || n == 8) ? "R6 sweep" : "R5 sweep",
                      op, model(4'(s), 4'(15 - s), 8'(n << 1)));
            end
        end
    endtask

    task automatic t_two_line();
        apply(4'b0011, 4'h0, 8'h42); check("R7 n1 two-line", op, 8'h04);
        apply(4'b0001, 4'h0, 8'h42); check("R7 low line dropped", op, 8'h01);
        for (int s = 0; s < 16; s++) begin
            apply(4'(s), 4'(s), 8'h4A);
            check("R7 sweep n5", op, model(4'(s), 4'(s), 8'h4A));
        end
    endtask

    task automatic t_priority();
        apply(4'b0101, 4'h0, 8'h22); check("R8 decode over mirror", op, 8'h20);
        apply(4'h0, 4'h0, 8'h28);    check("R8 n4 over mirror", op, 8'hFE);
    endtask

    task automatic t_fallback();
        apply(4'b1001, 4'b0110, 8'h12); check("R9 n9 pass", op, 8'h69);
        apply(4'b1001, 4'b0110, 8'h3E); check("R9 n15 mirror", op, 8'h69);
        apply(4'b0001, 4'b0010, 8'h5C); check("R9 n14 two-line ignored", op, 8'h21);
    endtask

    task automatic t_same_cycle();
        apply(4'b1111, 4'b0000, 8'h00);
        @(negedge clk);
        com_state = 4'b0010; unc_state = 4'b1011; cfg = 8'h2C;
        #2;
        check("R2 same-cycle old held", op, 8'h0F);
        @(negedge clk);
        check("R8 same-cycle new map", op, model(4'b0010, 4'b1011, 8'h2C));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", op, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_pass();
        t_hold();
        t_mirror();
        t_decode();
        t_two_line();
        t_priority();
        t_fallback();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 100000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule